// File: doc/BRIEF.md
# Serial 1-Wire CRC-8 Engine

This block folds a serial bit stream into the 8-bit cyclic redundancy check used on 1-Wire buses. It advances one bit per cycle on which `bit_valid` is high and holds otherwise. The register implements the polynomial x^8 + x^5 + x^4 + 1 in its bit-reversed (right-shifting) form, so bits are presented least significant bit first.

To generate a check value, clear the register and then stream the payload in. `crc_q` then holds the CRC byte. To check a received frame, clear the register and stream the payload followed by its received CRC byte, also LSB first. `crc_zero` goes high when the residue is zero, which marks the frame as intact.

A synchronous `clear` empties the register between frames. Framing, bus timing and byte assembly are left to the surrounding logic.

Top module: `ow_crc8_engine`

## Requirements
- R1: While `rst_n` is low, the register is all zeros. After `rst_n` rises, `crc_q` reads 8'h00 and `crc_zero` reads 1.
- R2: When `clear` is high at a rising clock edge, `crc_q` is 8'h00 after that edge.
- R3: When `clear` and `bit_valid` are high at the same edge, the clear wins and `crc_q` is 8'h00 after that edge.
- R4: At an edge where `bit_valid` and `clear` are both low, `crc_q` keeps its value whatever `bit_in` is.
- R5: At an edge where `bit_valid` is high and `clear` is low, let f = `crc_q[0]` XOR `bit_in`. The new `crc_q` is `crc_q` shifted right by one, XORed with 8'h8C when f is 1. This sets bit 7 and toggles bits 3 and 2.
- R6: Start from a cleared register and stream the bytes 02,1C,B8,01,00,00,00, each LSB first. `crc_q` then reads 8'hA2.
- R7: Start from a cleared register and stream any data followed by its CRC byte, LSB first. `crc_q` then returns to 8'h00.
- R8: `crc_zero` is 1 in exactly the cycles where `crc_q` equals 8'h00, with no added cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of the register; has priority over `bit_valid` |
| bit_valid | input | 1 | Advances the register by one bit at this edge |
| bit_in | input | 1 | Serial data bit, least significant bit first |
| crc_q | output | 8 | Current CRC register contents |
| crc_zero | output | 1 | High while the register is all zeros |

## Verification
The bench walks all 256 single-byte payloads. For each one it compares the register against an arithmetic model, then appends the computed CRC byte and expects a zero residue. A reversed polynomial tap or an MSB-first shift would show up at once as a mismatch on most bytes. The fixed seven-byte stream is checked against its known value of A2, and random multi-byte streams are checked the same way. The corner cases are also targeted:
- A clear in the same cycle as a valid bit: a design that lets the shift win would leave a nonzero residue.
- Idle cycles with `bit_in` toggling: a design that ignores `bit_valid` would drift.
- A zero flag that lags one cycle: it would disagree with `crc_q` right after the CRC byte completes.

// File: rtl/ow_crc_pkg.sv
package ow_crc_pkg;
    // Register width and reflected generator taps (x^8 + x^5 + x^4 + 1).
    localparam int unsigned CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_TAPS_REFL = 8'h8C;

    // Action applied to the register at a clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_CLEAR = 2'd2
    } crc_act_e;
endpackage

// File: rtl/ow_crc_step.sv
// Combinational single-bit advance of a right-shifting Galois LFSR.
module ow_crc_step #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] TAPS = 8'h8C
) (
    input  logic [W-1:0] cur,
    input  logic         din,
    output logic [W-1:0] nxt
);
    logic fb;
    assign fb = cur[0] ^ din;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == W - 1) begin : g_top
            assign nxt[i] = fb & TAPS[i];
        end else begin : g_mid
            assign nxt[i] = cur[i+1] ^ (fb & TAPS[i]);
        end
    end
endmodule

// File: rtl/ow_crc_reg.sv
// State register with clear-over-shift priority.
module ow_crc_reg
    import ow_crc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         bit_valid,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] cur
);
    crc_act_e act;

    always_comb begin
        if (clear)          act = ACT_CLEAR;
        else if (bit_valid) act = ACT_SHIFT;
        else                act = ACT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: cur <= '0;
                ACT_SHIFT: cur <= nxt;
                default:   cur <= cur;
            endcase
        end
    end
endmodule

// File: rtl/ow_crc8_engine.sv
module ow_crc8_engine
    import ow_crc_pkg::*;
#(
    parameter int unsigned WIDTH = CRC_W,
    parameter logic [WIDTH-1:0] POLY = CRC_TAPS_REFL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [WIDTH-1:0] crc_q,
    output logic             crc_zero
);
    logic [WIDTH-1:0] crc_next;

    ow_crc_step #(.W(WIDTH), .TAPS(POLY)) step_i (
        .cur (crc_q),
        .din (bit_in),
        .nxt (crc_next)
    );

    ow_crc_reg #(.W(WIDTH)) reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .bit_valid (bit_valid),
        .nxt       (crc_next),
        .cur       (crc_q)
    );

    assign crc_zero = (crc_q == '0);
endmodule

// File: rtl/ow_crc8_engine_chk.sv
module ow_crc8_engine_chk #(
    parameter int unsigned WIDTH = 8,
    parameter logic [WIDTH-1:0] POLY = 8'h8C
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             bit_valid,
    input logic             bit_in,
    input logic [WIDTH-1:0] crc_q,
    input logic             crc_zero
);
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (crc_q == '0 && crc_zero));

    assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc_q == '0));

    assert_clear_beats_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && bit_valid) |=> crc_zero);

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !bit_valid) |=> $stable(crc_q));

    assert_shift_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && bit_valid) |=>
            crc_q == (($past(crc_q) >> 1) ^ (($past(crc_q[0]) ^ $past(bit_in)) ? POLY : '0)));
endmodule

bind ow_crc8_engine ow_crc8_engine_chk #(.WIDTH(WIDTH), .POLY(POLY)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .crc_q     (crc_q),
    .crc_zero  (crc_zero)
);

// File: tb/ow_crc8_engine_tb.sv
module ow_crc8_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic [7:0] crc_q;
    logic       crc_zero;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ow_crc8_engine dut_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .bit_valid(bit_valid),
        .bit_in(bit_in), .crc_q(crc_q), .crc_zero(crc_zero)
    );

    // Arithmetic reference: one bit of the reflected 0x8C LFSR.
    function automatic logic [7:0] ref_bit(input logic [7:0] c, input logic b);
        logic f;
        f = c[0] ^ b;
        return (c >> 1) ^ (f ? 8'h8C : 8'h00);
    endfunction

    function automatic logic [7:0] ref_byte(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 0; i < 8; i++) r = ref_bit(r, d[i]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive for one edge, then sample 1 time unit after it.
    task automatic cyc(input logic c, input logic v, input logic b);
        @(negedge clk);
        clear = c; bit_valid = v; bit_in = b;
        @(posedge clk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] d);
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, d[i]);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] m;
        logic [7:0] held;
        logic [7:0] vec [7];
        vec = '{8'h02, 8'h1C, 8'hB8, 8'h01, 8'h00, 8'h00, 8'h00};

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 crc after reset", crc_q, 8'h00);
        chk("R1 zero after reset", {7'b0, crc_zero}, 8'h01);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);
        chk("R1 crc after release", crc_q, 8'h00);

        // R5: one step from zero with bit 1 gives 8C
        cyc(1'b0, 1'b1, 1'b1);
        chk("R5 single step", crc_q, 8'h8C);
        chk("R8 zero low when nonzero", {7'b0, crc_zero}, 8'h00);

        // R4: idle cycles with bit_in toggling hold the value
        held = crc_q;
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 1'b0, i[0]);
            chk("R4 hold while idle", crc_q, held);
        end

        // R2: plain clear
        cyc(1'b1, 1'b0, 1'b0);
        chk("R2 clear", crc_q, 8'h00);

        // R3: clear together with a valid bit
        send_byte(8'h5A);
        cyc(1'b1, 1'b1, 1'b1);
        chk("R3 clear beats shift", crc_q, 8'h00);
        chk("R8 zero after clear", {7'b0, crc_zero}, 8'h01);

        // R6: fixed stream
        m = 8'h00;
        foreach (vec[k]) begin
            send_byte(vec[k]);
            m = ref_byte(m, vec[k]);
        end
        chk("R6 known stream", crc_q, 8'hA2);
        chk("R6 model agrees", m, 8'hA2);
        send_byte(8'hA2);
        chk("R7 known stream residue", crc_q, 8'h00);
        chk("R8 known stream zero flag", {7'b0, crc_zero}, 8'h01);

        // R5/R7/R8: exhaustive single-byte sweep with per-bit model
        for (int d = 0; d < 256; d++) begin
            logic [7:0] db;
            logic [7:0] c;
            db = d[7:0];
            cyc(1'b1, 1'b0, 1'b0);
            m = 8'h00;
            for (int i = 0; i < 8; i++) begin
                cyc(1'b0, 1'b1, db[i]);
                m = ref_bit(m, db[i]);
            end
            chk("R5 byte sweep crc", crc_q, m);
            chk("R8 byte sweep flag", {7'b0, crc_zero}, {7'b0, (m == 8'h00)});
            c = m;
            send_byte(c);
            chk("R7 byte sweep residue", crc_q, 8'h00);
            chk("R8 byte sweep residue flag", {7'b0, crc_zero}, 8'h01);
        end

        // R5/R7: random multi-byte streams with interleaved idle cycles
        for (int s = 0; s < 40; s++) begin
            int len;
            len = 1 + ($urandom % 9);
            cyc(1'b1, 1'b0, 1'b0);
            m = 8'h00;
            for (int k = 0; k < len; k++) begin
                logic [7:0] d;
                d = 8'($urandom);
                for (int i = 0; i < 8; i++) begin
                    if (($urandom % 4) == 0) cyc(1'b0, 1'b0, ~d[i]);
                    cyc(1'b0, 1'b1, d[i]);
                    m = ref_bit(m, d[i]);
                end
            end
            chk("R5 random stream crc", crc_q, m);
            send_byte(m);
            chk("R7 random stream residue", crc_q, 8'h00);
        end

        finish_run();
    end
endmodule